// File: doc/BRIEF.md
# Debug-State Cache Policy Override

This block holds a three-bit cache policy word and applies it to the level-one cache traffic while the core is halted for debug. A debugger writes the word through a 32-bit register slave port. Each bit enables one normal behaviour, so a cleared bit applies a restriction. The restrictions are: write-back regions are treated as write-through, instruction-cache line-fills are blocked, and data-cache line-fills are blocked. Reset clears all three bits, so all restrictions are armed the first time the core halts.

The block sits between the cache access path and the cache control. Each instruction-side port presents a valid and a line-fill request. Each data-side port also presents a write-back attribute. The block returns the gated versions. A blocked fill is reported with a per-port suppression flag, so the access can complete as an uncached miss. Outside debug state every request passes through unchanged. The debug-state input is registered once, so an override starts or ends one clock after that input changes. The policy word can be written in any state, which lets software set it up before a halt.

Top module: `dbg_cache_policy`

## Requirements
- R1: After reset the policy word reads back as zero. Once the debug state is active, all three override outputs (`wt_force`, `ic_fill_block`, `dc_fill_block`) are high.
- R2: With bit 2 of the policy word at 0 and the debug state active, `wt_force` is high and every `d_wb_out` bit is 0. With bit 2 at 1, `d_wb_out` equals `d_wb_in`.
- R3: With bit 1 at 0 and the debug state active, `ic_fill_block` is high and every `i_fill_out` bit is 0. With bit 1 at 1, instruction fill requests pass unchanged.
- R4: With bit 0 at 0 and the debug state active, `dc_fill_block` is high and every `d_fill_out` bit is 0. With bit 0 at 1, data fill requests pass unchanged.
- R5: Bits [31:3] of the policy register always read as zero. Write data in those bits has no effect on the stored word.
- R6: While the debug state is not active, `i_fill_out`, `d_wb_out` and `d_fill_out` equal their inputs, and the three override outputs are low, whatever the policy word holds.
- R7: The debug state is a single registered copy of `dbg_halted`. Outputs change in the cycle after the clock edge that samples a rise or fall of `dbg_halted`, and not before that edge.
- R8: A suppression flag bit (`i_fill_supp` or `d_fill_supp`) is high exactly when that port's valid and fill request are both high and its side's fill is blocked.
- R9: A write with `reg_sel` and `reg_wr` high is stored at the clock edge in any debug state. `reg_rdata` shows the stored word only while `reg_sel` and `reg_rd` are high, and is zero otherwise.
- R10: Without both `reg_sel` and `reg_wr` high, the stored policy word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Selects the policy register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data; bit 2 write-back normal, bit 1 instruction fill enable, bit 0 data fill enable |
| reg_rdata | output | DATA_W | Read data |
| dbg_halted | input | 1 | Core is halted in debug state |
| wt_force | output | 1 | Write-back regions forced to write-through |
| ic_fill_block | output | 1 | Instruction line-fills blocked |
| dc_fill_block | output | 1 | Data line-fills blocked |
| i_valid | input | NUM_IPORTS | Instruction access valid per port |
| i_fill_req | input | NUM_IPORTS | Instruction line-fill request per port |
| i_fill_out | output | NUM_IPORTS | Gated instruction fill request |
| i_fill_supp | output | NUM_IPORTS | Instruction fill suppressed this cycle |
| d_valid | input | NUM_DPORTS | Data access valid per port |
| d_wb_in | input | NUM_DPORTS | Write-back attribute per port |
| d_fill_req | input | NUM_DPORTS | Data line-fill request per port |
| d_wb_out | output | NUM_DPORTS | Gated write-back attribute |
| d_fill_out | output | NUM_DPORTS | Gated data fill request |
| d_fill_supp | output | NUM_DPORTS | Data fill suppressed this cycle |

## Verification
A wrong stored policy bit shows on the next read of the register. It also shows on every access made while the debug state is active: a stray write-back attribute or fill request gets through, or a suppression flag is missing. A wrong registered debug state shows in the first cycle after `dbg_halted` changes, as gating that starts or ends one cycle early or late. The bench samples exactly that cycle on both the rise and the fall. A reserved-bit leak or a write taken without select shows on the next readback, one cycle after the write.

// File: rtl/dbg_cache_policy_pkg.sv
package dbg_cache_policy_pkg;

   // Number of implemented policy bits; positions are software visible.
   localparam int POLICY_W = 3;

   // Bit 2: write-back normal, bit 1: I-fill enable, bit 0: D-fill enable.
   // A cleared bit arms the matching restriction while in debug state.
   typedef struct packed {
      logic wb_normal;
      logic ifill_en;
      logic dfill_en;
   } policy_t;

   localparam policy_t POLICY_RESET = '{wb_normal: 1'b0, ifill_en: 1'b0, dfill_en: 1'b0};

endpackage

// File: rtl/dcp_regs.sv
module dcp_regs
   import dbg_cache_policy_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              dbg_halted,
   output policy_t           policy,
   output logic              dbg_active
);

   localparam int PAD_W = DATA_W - POLICY_W;

   policy_t policy_q;
   logic    dbg_q;
   logic    wr_en;
   logic    rd_en;
   logic    unused_wdata_hi;

   assign wr_en = reg_sel & reg_wr;
   assign rd_en = reg_sel & reg_rd;

   // Reserved write bits are dropped here.
   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:POLICY_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         policy_q <= POLICY_RESET;
      end else if (wr_en) begin
         policy_q <= policy_t'(reg_wdata[POLICY_W-1:0]);
      end
   end

   // Single registered copy of the debug-state input.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_q <= 1'b0;
      end else begin
         dbg_q <= dbg_halted;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign reg_rdata = rd_en ? {{PAD_W{1'b0}}, policy_q} : '0;
      end else begin : g_nopad
         assign reg_rdata = rd_en ? policy_q : '0;
      end
   endgenerate

   assign policy     = policy_q;
   assign dbg_active = dbg_q;

endmodule

// File: rtl/dcp_fill_gate.sv
module dcp_fill_gate #(
   parameter int PORTS = 1
) (
   input  logic             block,
   input  logic [PORTS-1:0] valid,
   input  logic [PORTS-1:0] fill_req,
   output logic [PORTS-1:0] fill_out,
   output logic [PORTS-1:0] suppressed
);

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign fill_out[p]   = fill_req[p] & ~block;
      assign suppressed[p] = valid[p] & fill_req[p] & block;
   end

endmodule

// File: rtl/dcp_wb_gate.sv
module dcp_wb_gate #(
   parameter int PORTS = 1
) (
   input  logic             force_wt,
   input  logic [PORTS-1:0] wb_in,
   output logic [PORTS-1:0] wb_out
);

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign wb_out[p] = wb_in[p] & ~force_wt;
   end

endmodule

// File: rtl/dbg_cache_policy.sv
module dbg_cache_policy
   import dbg_cache_policy_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_IPORTS = 1,
   parameter int NUM_DPORTS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_sel,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  dbg_halted,
   output logic                  wt_force,
   output logic                  ic_fill_block,
   output logic                  dc_fill_block,
   input  logic [NUM_IPORTS-1:0] i_valid,
   input  logic [NUM_IPORTS-1:0] i_fill_req,
   output logic [NUM_IPORTS-1:0] i_fill_out,
   output logic [NUM_IPORTS-1:0] i_fill_supp,
   input  logic [NUM_DPORTS-1:0] d_valid,
   input  logic [NUM_DPORTS-1:0] d_wb_in,
   input  logic [NUM_DPORTS-1:0] d_fill_req,
   output logic [NUM_DPORTS-1:0] d_wb_out,
   output logic [NUM_DPORTS-1:0] d_fill_out,
   output logic [NUM_DPORTS-1:0] d_fill_supp
);

   if (DATA_W < POLICY_W) begin : g_chk_width
      $error("dbg_cache_policy: DATA_W must hold the policy bits");
   end
   if (NUM_IPORTS < 1 || NUM_DPORTS < 1) begin : g_chk_ports
      $error("dbg_cache_policy: at least one port per side");
   end

   policy_t policy;
   logic    dbg_active;

   dcp_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_sel    (reg_sel),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .dbg_halted (dbg_halted),
      .policy     (policy),
      .dbg_active (dbg_active)
   );

   // Restrictions are active-low bits qualified by the registered debug state.
   assign wt_force      = dbg_active & ~policy.wb_normal;
   assign ic_fill_block = dbg_active & ~policy.ifill_en;
   assign dc_fill_block = dbg_active & ~policy.dfill_en;

   dcp_fill_gate #(.PORTS(NUM_IPORTS)) u_ifill (
      .block      (ic_fill_block),
      .valid      (i_valid),
      .fill_req   (i_fill_req),
      .fill_out   (i_fill_out),
      .suppressed (i_fill_supp)
   );

   dcp_fill_gate #(.PORTS(NUM_DPORTS)) u_dfill (
      .block      (dc_fill_block),
      .valid      (d_valid),
      .fill_req   (d_fill_req),
      .fill_out   (d_fill_out),
      .suppressed (d_fill_supp)
   );

   dcp_wb_gate #(.PORTS(NUM_DPORTS)) u_wb (
      .force_wt (wt_force),
      .wb_in    (d_wb_in),
      .wb_out   (d_wb_out)
   );

endmodule

// File: rtl/dbg_cache_policy_chk.sv
module dbg_cache_policy_chk
   import dbg_cache_policy_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_IPORTS = 1,
   parameter int NUM_DPORTS = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_sel,
   input logic                  reg_wr,
   input logic [DATA_W-1:0]     reg_rdata,
   input logic                  dbg_halted,
   input logic                  wt_force,
   input logic                  ic_fill_block,
   input logic                  dc_fill_block,
   input logic [NUM_IPORTS-1:0] i_fill_req,
   input logic [NUM_IPORTS-1:0] i_fill_out,
   input logic [NUM_IPORTS-1:0] i_fill_supp,
   input logic [NUM_DPORTS-1:0] d_wb_in,
   input logic [NUM_DPORTS-1:0] d_fill_req,
   input logic [NUM_DPORTS-1:0] d_wb_out,
   input logic [NUM_DPORTS-1:0] d_fill_out,
   input logic [NUM_DPORTS-1:0] d_fill_supp,
   input policy_t               policy
);

   assert_wt_clears_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wt_force |-> (d_wb_out == '0));

   assert_iblock_clears_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ic_fill_block |-> (i_fill_out == '0));

   assert_dblock_clears_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dc_fill_block |-> (d_fill_out == '0));

   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:POLICY_W] == '0);

   assert_pass_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_halted |=> (d_wb_out == d_wb_in && d_fill_out == d_fill_req
                       && i_fill_out == i_fill_req && !wt_force));

   assert_no_early_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_halted) |-> (!wt_force && !ic_fill_block && !dc_fill_block));

   assert_isupp_needs_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (i_fill_supp != '0) |-> ic_fill_block);

   assert_dsupp_needs_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (d_fill_supp != '0) |-> dc_fill_block);

   assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_sel && reg_wr) |=> $stable(policy));

endmodule

bind dbg_cache_policy dbg_cache_policy_chk #(
   .DATA_W     (DATA_W),
   .NUM_IPORTS (NUM_IPORTS),
   .NUM_DPORTS (NUM_DPORTS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_sel       (reg_sel),
   .reg_wr        (reg_wr),
   .reg_rdata     (reg_rdata),
   .dbg_halted    (dbg_halted),
   .wt_force      (wt_force),
   .ic_fill_block (ic_fill_block),
   .dc_fill_block (dc_fill_block),
   .i_fill_req    (i_fill_req),
   .i_fill_out    (i_fill_out),
   .i_fill_supp   (i_fill_supp),
   .d_wb_in       (d_wb_in),
   .d_fill_req    (d_fill_req),
   .d_wb_out      (d_wb_out),
   .d_fill_out    (d_fill_out),
   .d_fill_supp   (d_fill_supp),
   .policy        (policy)
);

// File: tb/dbg_cache_policy_test.sv
module dbg_cache_policy_test;

   localparam int DW = 32;
   localparam int NI = 1;
   localparam int ND = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          dbg_halted = 1'b0;
   logic          wt_force, ic_fill_block, dc_fill_block;
   logic [NI-1:0] i_valid = '0, i_fill_req = '0, i_fill_out, i_fill_supp;
   logic [ND-1:0] d_valid = '0, d_wb_in = '0, d_fill_req = '0;
   logic [ND-1:0] d_wb_out, d_fill_out, d_fill_supp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   dbg_cache_policy #(.DATA_W(DW), .NUM_IPORTS(NI), .NUM_DPORTS(ND)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halted(dbg_halted),
      .wt_force(wt_force), .ic_fill_block(ic_fill_block), .dc_fill_block(dc_fill_block),
      .i_valid(i_valid), .i_fill_req(i_fill_req), .i_fill_out(i_fill_out),
      .i_fill_supp(i_fill_supp), .d_valid(d_valid), .d_wb_in(d_wb_in),
      .d_fill_req(d_fill_req), .d_wb_out(d_wb_out), .d_fill_out(d_fill_out),
      .d_fill_supp(d_fill_supp)
   );

   typedef struct packed {
      logic [2:0] pol;
      logic       dbg;
      logic       iv;
      logic       ifr;
      logic [1:0] dv;
      logic [1:0] dwb;
      logic [1:0] dfr;
      logic       e_ifo;
      logic       e_isup;
      logic [1:0] e_dwb;
      logic [1:0] e_dfo;
      logic [1:0] e_dsup;
   } vec_t;

   localparam int NV = 9;
   // pol, dbg, iv, ifr, dv, dwb, dfr | ifo, isup, dwb_o, dfo, dsup
   localparam vec_t VECS [NV] = '{
      '{3'b000, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 2'b11, 2'b11, 2'b00},
      '{3'b000, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1, 2'b00, 2'b00, 2'b11},
      '{3'b100, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1, 2'b11, 2'b00, 2'b11},
      '{3'b010, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 2'b00, 2'b00, 2'b11},
      '{3'b001, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b11, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00},
      '{3'b111, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1, 1'b0, 2'b11, 2'b11, 2'b00},
      '{3'b000, 1'b1, 1'b0, 1'b1, 2'b01, 2'b10, 2'b11, 1'b0, 1'b0, 2'b00, 2'b00, 2'b01},
      '{3'b000, 1'b0, 1'b0, 1'b0, 2'b10, 2'b10, 2'b01, 1'b0, 1'b0, 2'b10, 2'b01, 2'b00},
      '{3'b011, 1'b1, 1'b1, 1'b1, 2'b11, 2'b01, 2'b10, 1'b1, 1'b0, 2'b00, 2'b10, 2'b00}
   };

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_reg(input logic [DW-1:0] val, input logic sel, input logic wr);
      reg_sel = sel; reg_wr = wr; reg_rd = 1'b0; reg_wdata = val;
      tick();
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic read_reg(output logic [DW-1:0] val);
      reg_sel = 1'b1; reg_rd = 1'b1;
      #1 val = reg_rdata;
      reg_sel = 1'b0; reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      read_reg(rd);
      check("R1", "reset readback", rd, 32'h0);
      check("R6", "overrides idle outside debug", {29'b0, wt_force, ic_fill_block, dc_fill_block}, 32'h0);
      dbg_halted = 1'b1;
      tick();
      #1;
      check("R1", "reset overrides armed", {29'b0, wt_force, ic_fill_block, dc_fill_block}, 32'h7);
      dbg_halted = 1'b0;
      tick();

      // Vector table
      for (int k = 0; k < NV; k++) begin
         string tag_wb, tag_if, tag_df, tag_sup;
         write_reg({29'b0, VECS[k].pol}, 1'b1, 1'b1);
         dbg_halted = VECS[k].dbg;
         tick();
         i_valid = VECS[k].iv; i_fill_req = VECS[k].ifr;
         d_valid = VECS[k].dv; d_wb_in = VECS[k].dwb; d_fill_req = VECS[k].dfr;
         #1;
         tag_wb  = VECS[k].dbg ? "R2" : "R6";
         tag_if  = VECS[k].dbg ? "R3" : "R6";
         tag_df  = VECS[k].dbg ? "R4" : "R6";
         tag_sup = "R8";
         check(tag_wb, $sformatf("vec%0d d_wb_out", k), {30'b0, d_wb_out}, {30'b0, VECS[k].e_dwb});
         check(tag_if, $sformatf("vec%0d i_fill_out", k), {31'b0, i_fill_out}, {31'b0, VECS[k].e_ifo});
         check(tag_df, $sformatf("vec%0d d_fill_out", k), {30'b0, d_fill_out}, {30'b0, VECS[k].e_dfo});
         check(tag_sup, $sformatf("vec%0d i_fill_supp", k), {31'b0, i_fill_supp}, {31'b0, VECS[k].e_isup});
         check(tag_sup, $sformatf("vec%0d d_fill_supp", k), {30'b0, d_fill_supp}, {30'b0, VECS[k].e_dsup});
         read_reg(rd);
         check("R9", $sformatf("vec%0d readback", k), rd, {29'b0, VECS[k].pol});
      end

      // R5: reserved bits
      write_reg(32'hFFFF_FFFF, 1'b1, 1'b1);
      read_reg(rd);
      check("R5", "all-ones write readback", rd, 32'h7);
      write_reg(32'hFFFF_FFF8, 1'b1, 1'b1);
      read_reg(rd);
      check("R5", "reserved-only write readback", rd, 32'h0);

      // R10: writes without select or strobe
      write_reg(32'h5, 1'b0, 1'b1);
      read_reg(rd);
      check("R10", "write without select", rd, 32'h0);
      write_reg(32'h5, 1'b1, 1'b0);
      read_reg(rd);
      check("R10", "select without write", rd, 32'h0);

      // R9: readback gated by strobes
      write_reg(32'h6, 1'b1, 1'b1);
      reg_sel = 1'b1; reg_rd = 1'b0;
      #1 check("R9", "rdata without read strobe", reg_rdata, 32'h0);
      reg_sel = 1'b0; reg_rd = 1'b1;
      #1 check("R9", "rdata without select", reg_rdata, 32'h0);
      reg_rd = 1'b0;

      // R7: one-cycle latency on both edges (policy 000, dbg low now? ensure)
      write_reg(32'h0, 1'b1, 1'b1);
      dbg_halted = 1'b0;
      tick();
      d_valid = 2'b11; d_wb_in = 2'b11; d_fill_req = 2'b11;
      i_valid = 1'b1; i_fill_req = 1'b1;
      dbg_halted = 1'b1;
      #1;
      check("R7", "before edge after rise wb", {30'b0, d_wb_out}, 32'h3);
      check("R7", "before edge after rise ifill", {31'b0, i_fill_out}, 32'h1);
      @(posedge clk); #1;
      check("R7", "after edge rise wb", {30'b0, d_wb_out}, 32'h0);
      check("R7", "after edge rise dfill", {30'b0, d_fill_out}, 32'h0);
      @(negedge clk);

      // R9: write while halted takes effect after its edge
      write_reg(32'h4, 1'b1, 1'b1);
      #1 check("R9", "write in debug wb", {30'b0, d_wb_out}, 32'h3);

      write_reg(32'h0, 1'b1, 1'b1);
      dbg_halted = 1'b0;
      #1;
      check("R7", "before edge after fall wb", {30'b0, d_wb_out}, 32'h0);
      @(posedge clk); #1;
      check("R7", "after edge fall wb", {30'b0, d_wb_out}, 32'h3);
      check("R7", "after edge fall supp", {30'b0, d_fill_supp}, 32'h0);
      @(negedge clk);

      finish_run();
   end

endmodule